// File: doc/BRIEF.md
# Multi-View General Register File

This block holds eight 32-bit general registers. Software-visible operands can see the same storage in three ways: as a full 32-bit word, as either 16-bit half of a register, or as either byte of the lower half. An execution datapath reads two operands and writes one result per cycle. Each port carries a register field and a size code, and the file translates them into the right slice of the right register. An address generator has a separate read port that always returns the full 32-bit value.

A narrow write is a read-modify-write of one register that happens within a single cycle. Only the addressed slice changes, and every other bit of that register keeps its value. Reads are combinational and return the contents from before the clock edge, so a result written in a cycle becomes visible to readers in the next cycle.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. In the cycle after reset is released, every register reads zero on every port.
- R2: Size code 2 selects the 32-bit view. A write stores all 32 bits of `wr_data` into the register `field[2:0]`, and a read returns all 32 bits of that register.
- R3: Size code 1 selects a 16-bit view of register `field[2:0]`. When `field[3]` is 1 the view is bits 31:16, and when it is 0 the view is bits 15:0. A read places the half in bits 15:0 and drives bits 31:16 to zero.
- R4: Size code 0 selects an 8-bit view of register `field[2:0]`. When `field[3]` is 1 the view is bits 7:0, and when it is 0 the view is bits 15:8. A read places the byte in bits 7:0 and drives bits 31:8 to zero.
- R5: A 16-bit write loads the selected half from `wr_data[15:0]`, and the other half of the register is unchanged.
- R6: A byte write loads the selected byte from `wr_data[7:0]`, and the other 24 bits of the register are unchanged.
- R7: A read that addresses the register being written in the same cycle returns the old contents. The new value is visible from the cycle after the edge.
- R8: While `wr_en` is 0, no register changes, whatever values the other write inputs carry.
- R9: The two operand read ports are independent. Each one returns the view given by its own field and size code, including when both ports address the same register.
- R10: The address port returns all 32 bits of register `ad_reg`, whatever the size codes on the other ports.
- R11: Size code 3 behaves as the 32-bit view. In every 32-bit access, field bit 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_size | input | 2 | Write size code (0 byte, 1 half, 2 or 3 word) |
| wr_reg | input | 4 | Write register field |
| wr_data | input | 32 | Write data, right-aligned for narrow views |
| ra_size | input | 2 | Operand A size code |
| ra_reg | input | 4 | Operand A register field |
| ra_data | output | 32 | Operand A view, zero-extended |
| rb_size | input | 2 | Operand B size code |
| rb_reg | input | 4 | Operand B register field |
| rb_data | output | 32 | Operand B view, zero-extended |
| ad_reg | input | 3 | Address port register number |
| ad_data | output | 32 | Full contents of register `ad_reg` |

## Verification
The hardest case to reach is a narrow write that lands in a register in the same cycle as a read of that register through a different view. That one cycle exercises both the merge and the old-value read. Directed steps first build a known pattern in one register and then walk through every half and byte write, checking the neighbouring slices through the full-width address port. After that, a long random phase keeps register numbers inside a small range so that collisions between the write and the reads happen often. Every clock is compared against a behavioural model of the eight registers.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } gpr_size_e;
endpackage

// File: rtl/gpr_view_read.sv
module gpr_view_read #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] word,
  input  logic [1:0]      size,
  input  logic            sel_hi,
  output logic [XLEN-1:0] view
);
  import gpr_pkg::*;
  localparam int HW = XLEN / 2;
  localparam int BW = XLEN / 4;

  always_comb begin
    view = '0;
    case (gpr_size_e'(size))
      SZ_BYTE: view[BW-1:0] = sel_hi ? word[BW-1:0] : word[2*BW-1:BW];
      SZ_HALF: view[HW-1:0] = sel_hi ? word[XLEN-1:HW] : word[HW-1:0];
      default: view = word;
    endcase
  end
endmodule

// File: rtl/gpr_view_merge.sv
module gpr_view_merge #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_word,
  input  logic [XLEN-1:0] data,
  input  logic [1:0]      size,
  input  logic            sel_hi,
  output logic [XLEN-1:0] merged
);
  import gpr_pkg::*;
  localparam int HW = XLEN / 2;
  localparam int BW = XLEN / 4;

  always_comb begin
    merged = old_word;
    case (gpr_size_e'(size))
      SZ_BYTE: begin
        if (sel_hi) merged[BW-1:0]    = data[BW-1:0];
        else        merged[2*BW-1:BW] = data[BW-1:0];
      end
      SZ_HALF: begin
        if (sel_hi) merged[XLEN-1:HW] = data[HW-1:0];
        else        merged[HW-1:0]    = data[HW-1:0];
      end
      default: merged = data;
    endcase
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int NREG = 8,
  parameter int XLEN = 32,
  localparam int IDXW = $clog2(NREG),
  localparam int FW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_size,
  input  logic [FW-1:0]   wr_reg,
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      ra_size,
  input  logic [FW-1:0]   ra_reg,
  output logic [XLEN-1:0] ra_data,
  input  logic [1:0]      rb_size,
  input  logic [FW-1:0]   rb_reg,
  output logic [XLEN-1:0] rb_data,
  input  logic [IDXW-1:0] ad_reg,
  output logic [XLEN-1:0] ad_data
);
  localparam int NRD = 2;

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] wr_old, wr_new;
  logic [IDXW-1:0] wr_idx;

  logic [1:0]      rd_size [NRD];
  logic [FW-1:0]   rd_reg  [NRD];
  logic [XLEN-1:0] rd_view [NRD];

  assign wr_idx = wr_reg[IDXW-1:0];
  assign wr_old = regs[wr_idx];

  gpr_view_merge #(.XLEN(XLEN)) u_merge (
    .old_word(wr_old),
    .data    (wr_data),
    .size    (wr_size),
    .sel_hi  (wr_reg[FW-1]),
    .merged  (wr_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < NREG)) begin
      regs[wr_idx] <= wr_new;
    end
  end

  assign rd_size[0] = ra_size;
  assign rd_reg[0]  = ra_reg;
  assign rd_size[1] = rb_size;
  assign rd_reg[1]  = rb_reg;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    gpr_view_read #(.XLEN(XLEN)) u_read (
      .word  (regs[rd_reg[p][IDXW-1:0]]),
      .size  (rd_size[p]),
      .sel_hi(rd_reg[p][FW-1]),
      .view  (rd_view[p])
    );
  end

  assign ra_data = rd_view[0];
  assign rb_data = rd_view[1];
  assign ad_data = regs[ad_reg];
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int NREG = 8,
  parameter int XLEN = 32,
  localparam int IDXW = $clog2(NREG),
  localparam int FW = IDXW + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [1:0]      wr_size,
  input logic [FW-1:0]   wr_reg,
  input logic [XLEN-1:0] wr_data,
  input logic [1:0]      ra_size,
  input logic [FW-1:0]   ra_reg,
  input logic [XLEN-1:0] ra_data,
  input logic [1:0]      rb_size,
  input logic [FW-1:0]   rb_reg,
  input logic [XLEN-1:0] rb_data,
  input logic [IDXW-1:0] ad_reg,
  input logic [XLEN-1:0] ad_data
);
  localparam int HW = XLEN / 2;
  localparam int BW = XLEN / 4;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ad_data == '0 && ra_data == '0 && rb_data == '0));

  assert_word_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_size[1]) &&
     ad_reg == $past(wr_reg[IDXW-1:0])) |-> ad_data == $past(wr_data));

  assert_half_view_R3: assert property (@(posedge clk) disable iff (rst)
    (ra_size == 2'd1 && ra_reg[IDXW-1:0] == ad_reg) |->
      (ra_data[XLEN-1:HW] == '0 &&
       ra_data[HW-1:0] == (ra_reg[FW-1] ? ad_data[XLEN-1:HW] : ad_data[HW-1:0])));

  assert_byte_view_R4: assert property (@(posedge clk) disable iff (rst)
    (rb_size == 2'd0 && rb_reg[IDXW-1:0] == ad_reg) |->
      (rb_data[XLEN-1:BW] == '0 &&
       rb_data[BW-1:0] == (rb_reg[FW-1] ? ad_data[BW-1:0] : ad_data[2*BW-1:BW])));

  assert_half_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_size) == 2'd1 && !$past(wr_reg[FW-1]) &&
     $past(ad_reg) == ad_reg && ad_reg == $past(wr_reg[IDXW-1:0])) |->
      (ad_data[XLEN-1:HW] == $past(ad_data[XLEN-1:HW]) &&
       ad_data[HW-1:0] == $past(wr_data[HW-1:0])));

  assert_byte_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_size) == 2'd0 && $past(wr_reg[FW-1]) &&
     $past(ad_reg) == ad_reg && ad_reg == $past(wr_reg[IDXW-1:0])) |->
      (ad_data[XLEN-1:BW] == $past(ad_data[XLEN-1:BW]) &&
       ad_data[BW-1:0] == $past(wr_data[BW-1:0])));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(ad_reg)) |-> $stable(ad_data));
endmodule

bind gpr_file gpr_file_chk #(.NREG(NREG), .XLEN(XLEN)) u_chk (.*);

// File: tb/test_gpr_file.sv
module test_gpr_file;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [1:0]  wr_size = 0;
  logic [3:0]  wr_reg = 0;
  logic [31:0] wr_data = 0;
  logic [1:0]  ra_size = 2, rb_size = 2;
  logic [3:0]  ra_reg = 0, rb_reg = 0;
  logic [2:0]  ad_reg = 0;
  logic [31:0] ra_data, rb_data, ad_data;
  int total = 0, bad = 0;
  logic [31:0] mdl [8];

  always #4 clk = ~clk;

  gpr_file i_gpr_file (.*);

  function automatic logic [31:0] view_of(logic [31:0] w, logic [1:0] sz, logic [3:0] f);
    case (sz)
      2'd0: return f[3] ? {24'h0, w[7:0]} : {24'h0, w[15:8]};
      2'd1: return f[3] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] merge_of(logic [31:0] w, logic [31:0] d, logic [1:0] sz, logic [3:0] f);
    logic [31:0] r = w;
    case (sz)
      2'd0: if (f[3]) r[7:0] = d[7:0]; else r[15:8] = d[7:0];
      2'd1: if (f[3]) r[31:16] = d[15:0]; else r[15:0] = d[15:0];
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] sz);
    case (sz)
      2'd0: return "R4";
      2'd1: return "R3";
      2'd2: return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare all outputs with the model mid-cycle, then advance one clock.
  task automatic step();
    #2;
    if (!rst) begin
      chk({tag_of(ra_size), " port A"}, ra_data, view_of(mdl[ra_reg[2:0]], ra_size, ra_reg));
      chk({tag_of(rb_size), " R9 port B"}, rb_data, view_of(mdl[rb_reg[2:0]], rb_size, rb_reg));
      chk("R10 address port", ad_data, mdl[ad_reg]);
    end
    @(posedge clk);
    if (rst) for (int i = 0; i < 8; i++) mdl[i] = 0;
    else if (wr_en) mdl[wr_reg[2:0]] = merge_of(mdl[wr_reg[2:0]], wr_data, wr_size, wr_reg);
    @(negedge clk);
  endtask

  task automatic peek(logic [2:0] idx, logic [31:0] exp, string tag);
    ad_reg = idx;
    #1;
    chk(tag, ad_data, exp);
  endtask

  task automatic wr(logic [1:0] sz, logic [3:0] f, logic [31:0] d);
    wr_en = 1; wr_size = sz; wr_reg = f; wr_data = d;
    step();
    wr_en = 0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 32'hFFFF_FFFF;
    // Preload non-zero contents so that reset has something to clear.
    rst = 0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      wr_en = 1; wr_size = 2; wr_reg = 4'(i); wr_data = 32'hDEAD_0000 + 32'(i);
      @(negedge clk);
    end
    wr_en = 0;
    rst = 1;
    step();
    step();
    rst = 0;
    for (int i = 0; i < 8; i++) peek(3'(i), 32'h0, "R1 reset clear");

    // R7: read during a word write returns the old value
    wr_en = 1; wr_size = 2; wr_reg = 4'd3; wr_data = 32'hA1B2_C3D4;
    ra_size = 2; ra_reg = 4'd3;
    #2 chk("R7 old value during write", ra_data, 32'h0);
    step();
    wr_en = 0;
    chk("R7 new value after edge", ra_data, 32'hA1B2_C3D4);
    peek(3, 32'hA1B2_C3D4, "R2 word write");

    wr(2'd1, 4'b1011, 32'hFFFF_1234);
    peek(3, 32'h1234_C3D4, "R5 upper half write");
    wr(2'd1, 4'b0011, 32'h0000_9876);
    peek(3, 32'h1234_9876, "R5 lower half write");
    ra_size = 1; ra_reg = 4'b1011; rb_size = 1; rb_reg = 4'b0011;
    #1 chk("R3 upper half read", ra_data, 32'h0000_1234);
    chk("R3 R9 lower half read", rb_data, 32'h0000_9876);

    wr(2'd0, 4'b1011, 32'hFFFF_FF5A);
    peek(3, 32'h1234_985A, "R6 low byte write");
    wr(2'd0, 4'b0011, 32'h0000_0077);
    peek(3, 32'h1234_775A, "R6 high byte write");
    ra_size = 0; ra_reg = 4'b0011; rb_size = 0; rb_reg = 4'b1011;
    #1 chk("R4 high byte read", ra_data, 32'h0000_0077);
    chk("R4 R9 low byte read", rb_data, 32'h0000_005A);

    wr_en = 0; wr_size = 2; wr_reg = 4'd3; wr_data = 32'h5555_5555;
    step();
    peek(3, 32'h1234_775A, "R8 disabled write ignored");

    wr(2'd3, 4'b1101, 32'hCAFE_F00D);
    peek(5, 32'hCAFE_F00D, "R11 size 3 full write");
    ra_size = 2; ra_reg = 4'b1101;
    #1 chk("R11 top field bit ignored", ra_data, 32'hCAFE_F00D);

    // Random phase with dense register collisions
    for (int n = 0; n < 3000; n++) begin
      wr_en   = ($urandom_range(0, 3) != 0);
      wr_size = 2'($urandom_range(0, 3));
      wr_reg  = {1'($urandom_range(0, 1)), 3'($urandom_range(0, 3))};
      wr_data = $urandom;
      ra_size = 2'($urandom_range(0, 3));
      ra_reg  = {1'($urandom_range(0, 1)), 3'($urandom_range(0, 3))};
      rb_size = 2'($urandom_range(0, 3));
      rb_reg  = {1'($urandom_range(0, 1)), 3'($urandom_range(0, 3))};
      ad_reg  = 3'($urandom_range(0, 7));
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule